// File: doc/BRIEF.md
# Banked Strided Vector Load Engine

This block fetches one vector operand from an interleaved word memory and writes it into a vector register. Software-visible work is a single start pulse carrying a base word address, a constant stride and an element count. The engine then walks the elements in order, computing each address as the base plus the element number times the stride, and sends each request to the bank chosen by the low address bits. The banks are internal fixed-latency models. Each bank needs a rest period after an access before it can take another.

The rate at which requests go out depends on how the stride spreads addresses over the banks. Strides that touch many distinct banks stream at one element per cycle. Strides that fold onto a few banks are held back by the bank rest time. Each returned word carries its element number, so it lands in its own slot of the register. A one-cycle completion pulse marks the write of the final element. The register is read through a plain index port.

Top module: `vload_engine`

## Requirements
- R1: The request for element i carries the word address (base + i * stride) modulo 2^AW, with the stride taken as two's complement. Requests appear on req_addr while req_valid is high, at most one per cycle, in strictly ascending element order.
- R2: req_bank equals req_addr modulo NBANK (default 16 banks).
- R3: After a bank takes a request in cycle t, it takes no other request before cycle t + BUSY (default 4). A request whose bank is resting is held and retried every cycle. It goes out in the first cycle in which its bank is free and the previous element has gone out.
- R4: The word for a request issued in cycle t is written in cycle t + LAT (default 12) into register slot i, where i is the element number. The memory word at address a is {~a, a}, with the complement in the upper AW bits. After completion, rd_data shows slot rd_idx.
- R5: With unit stride and NBANK at least BUSY, the vl requests go out in vl consecutive cycles. The first goes out in the cycle after the start is accepted.
- R6: Strides that map the elements onto fewer than BUSY banks stall. A stride of 8 with 16 banks alternates between two banks and issues two requests per BUSY cycles. A stride of zero, or one equal to NBANK, hits a single bank and issues one request every BUSY cycles.
- R7: done is high for exactly one cycle, LAT cycles after the last request. busy falls in the following cycle.
- R8: A start is accepted only while busy is low and vl is nonzero; vl must lie in 1..VLMAX. A start while busy, or a start with vl of zero, is ignored. It produces no request and leaves the running load unchanged.
- R9: During and right after reset, busy, req_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load with the values on base, stride and vl |
| base | input | AW | Word address of element 0 |
| stride | input | AW | Two's complement word distance between elements |
| vl | input | $clog2(VLMAX+1) | Number of elements, 1..VLMAX |
| rd_idx | input | $clog2(VLMAX) | Register slot to read |
| busy | output | 1 | A load is in progress |
| req_valid | output | 1 | A bank request goes out this cycle |
| req_addr | output | AW | Word address of the request |
| req_bank | output | $clog2(NBANK) | Bank of the request |
| done | output | 1 | Final element written this cycle |
| rd_data | output | 2*AW | Contents of slot rd_idx |

## Verification
The bench predicts the exact cycle of every request and of the completion pulse, for strides that stream, fold onto two banks, hit a single bank, are zero, or step backwards across address zero. A design that released a held request early, lost a cycle after a stall, or took the bank from the wrong address bits would shift the cycle or address of a request. A stray start pulse in the middle of a load, and a start with zero length, must leave no trace; a design that accepted either would issue requests the scoreboard does not expect. Every register slot is read back afterwards, so a design that wrote returned words by arrival order would show misplaced data, as would one with a latency off by one cycle.

// File: rtl/vload_engine.sv
module vload_engine #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int AW    = 16,
  parameter int VLMAX = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [AW-1:0]                base,
  input  logic [AW-1:0]                stride,
  input  logic [$clog2(VLMAX+1)-1:0]   vl,
  input  logic [$clog2(VLMAX)-1:0]     rd_idx,
  output logic                         busy,
  output logic                         req_valid,
  output logic [AW-1:0]                req_addr,
  output logic [$clog2(NBANK)-1:0]     req_bank,
  output logic                         done,
  output logic [2*AW-1:0]              rd_data
);
  localparam int DW = 2 * AW;
  localparam int IW = $clog2(VLMAX);
  localparam int LW = $clog2(VLMAX + 1);
  localparam int BW = $clog2(NBANK);
  localparam int CW = $clog2(BUSY + 1);

  logic          active;
  logic [LW-1:0] len, nxt;
  logic [AW-1:0] addr, step;
  logic [BW-1:0] bank;
  logic [CW-1:0] rest [NBANK];
  logic          pv [LAT];
  logic [IW-1:0] pi [LAT];
  logic [AW-1:0] pa [LAT];
  logic [DW-1:0] vreg [VLMAX];

  assign bank      = BW'(addr % AW'(NBANK));
  assign req_valid = active && (nxt < len) && (rest[bank] == '0);
  assign req_addr  = addr;
  assign req_bank  = bank;
  assign busy      = active;
  assign done      = pv[LAT-1] && (LW'(pi[LAT-1]) == len - LW'(1));
  assign rd_data   = vreg[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      len    <= '0;
      nxt    <= '0;
      addr   <= '0;
      step   <= '0;
    end else if (!active) begin
      if (start && vl != '0) begin
        active <= 1'b1;
        len    <= vl;
        nxt    <= '0;
        addr   <= base;
        step   <= stride;
      end
    end else begin
      if (req_valid) begin
        addr <= addr + step;
        nxt  <= nxt + LW'(1);
      end
      if (done) active <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                           rest[b] <= '0;
      else if (req_valid && bank == BW'(b)) rest[b] <= CW'(BUSY - 1);
      else if (rest[b] != '0)               rest[b] <= rest[b] - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= req_valid;
      for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pi[0] <= nxt[IW-1:0];
    pa[0] <= addr;
    for (int k = 1; k < LAT; k++) begin
      pi[k] <= pi[k-1];
      pa[k] <= pa[k-1];
    end
    if (pv[LAT-1]) vreg[pi[LAT-1]] <= {~pa[LAT-1], pa[LAT-1]};
  end
endmodule

// File: rtl/vload_engine_chk.sv
module vload_engine_chk #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int AW    = 16,
  parameter int VLMAX = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic [AW-1:0]              base,
  input logic [AW-1:0]              stride,
  input logic [$clog2(VLMAX+1)-1:0] vl,
  input logic                       busy,
  input logic                       req_valid,
  input logic [AW-1:0]              req_addr,
  input logic [$clog2(NBANK)-1:0]   req_bank,
  input logic                       done
);
  logic [AW-1:0] exp_addr, exp_step;
  logic [7:0]    left [NBANK];
  logic [15:0]   since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_addr <= '0;
      exp_step <= '0;
    end else if (!busy && start && vl != '0) begin
      exp_addr <= base;
      exp_step <= stride;
    end else if (req_valid) begin
      exp_addr <= exp_addr + exp_step;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBANK; b++) begin
      if (!rst_n)                                            left[b] <= '0;
      else if (req_valid && int'(req_bank) == b)             left[b] <= 8'(BUSY - 1);
      else if (left[b] != '0)                                left[b] <= left[b] - 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               since <= 16'hFFFF;
    else if (req_valid)       since <= '0;
    else if (since != 16'hFFFF) since <= since + 16'd1;
  end

  a_r1_addr_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr == exp_addr);
  a_r3_bank_rest: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> left[req_bank] == '0);
  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> since == 16'(LAT - 1));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !done);
endmodule

bind vload_engine vload_engine_chk #(
  .NBANK(NBANK), .BUSY(BUSY), .LAT(LAT), .AW(AW), .VLMAX(VLMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
  .vl(vl), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
  .req_bank(req_bank), .done(done)
);

// File: tb/vload_engine_bench.sv
`timescale 1ns/1ps
module vload_engine_bench;
  localparam int NB = 16, BUSY = 4, LAT = 12, AW = 16, VLMAX = 64;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] base = 0, stride = 0;
  logic [6:0]  vl = 0;
  logic [5:0]  rd_idx = 0;
  logic        busy, req_valid, done;
  logic [15:0] req_addr;
  logic [3:0]  req_bank;
  logic [31:0] rd_data;

  int cyc = 0, nchk = 0, nfail = 0;
  int q_cyc[$];
  logic [15:0] q_addr[$];

  vload_engine u_vload_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vl(vl), .rd_idx(rd_idx), .busy(busy), .req_valid(req_valid),
    .req_addr(req_addr), .req_bank(req_bank), .done(done), .rd_data(rd_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (q_cyc.size() == 0) begin
        chk(0, "R8", "unexpected request addr", longint'(req_addr), 0);
      end else begin
        int ec;
        logic [15:0] ea;
        ec = q_cyc.pop_front();
        ea = q_addr.pop_front();
        chk(cyc == ec, "R3", "request cycle", cyc, ec);
        chk(req_addr == ea, "R1", "request address", req_addr, ea);
        chk(req_bank == 4'(ea % NB), "R2", "request bank", req_bank, ea % NB);
      end
    end
  end

  task automatic run(input logic [15:0] b, input logic [15:0] s, input int n,
                     input bit intrude, input string req);
    int fr[NB];
    int t, k, exp_done, got_done;
    logic [15:0] a;
    @(negedge clk);
    k = cyc;
    foreach (fr[j]) fr[j] = 0;
    t = 1;
    for (int i = 0; i < n; i++) begin
      int bb;
      a  = b + 16'(i) * s;
      bb = int'(a) % NB;
      if (t < fr[bb]) t = fr[bb];
      q_cyc.push_back(k + t);
      q_addr.push_back(a);
      fr[bb] = t + BUSY;
      t++;
    end
    exp_done = k + t - 1 + LAT;
    base = b; stride = s; vl = 7'(n); start = 1;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      base = 16'h7777; stride = 16'd1; vl = 7'd5; start = 1;
      @(negedge clk);
      start = 0;
    end
    got_done = -1;
    for (int w = 0; w < 4000 && got_done < 0; w++) begin
      if (done) got_done = cyc;
      else @(negedge clk);
    end
    chk(got_done == exp_done, req, "done cycle", got_done, exp_done);
    @(negedge clk);
    chk(!done, "R7", "done width", done, 0);
    chk(!busy, "R7", "busy after done", busy, 0);
    chk(q_cyc.size() == 0, "R1", "requests left", q_cyc.size(), 0);
    for (int i = 0; i < n; i++) begin
      a = b + 16'(i) * s;
      rd_idx = 6'(i);
      #1;
      chk(rd_data == {~a, a}, "R4", $sformatf("slot %0d", i), rd_data, {~a, a});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done, "R9", "outputs in reset",
        {busy, req_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R9", "outputs after reset",
        {busy, req_valid, done}, 0);

    run(16'h0100, 16'd1, 64, 0, "R5");
    run(16'h0203, 16'd3, 20, 0, "R1");
    run(16'h0100, 16'd8, 16, 0, "R6");
    run(16'h0040, 16'd16, 8, 0, "R6");
    run(16'h0007, 16'd0, 10, 0, "R6");
    run(16'h0005, 16'hFFFF, 12, 0, "R1");
    run(16'h0AB3, 16'd5, 1, 0, "R7");
    run(16'h0300, 16'd2, 30, 1, "R8");

    @(negedge clk);
    base = 16'h1234; stride = 16'd1; vl = 7'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk(!busy, "R8", "zero length start busy", busy, 0);
    repeat (20) @(negedge clk);
    chk(!busy && !req_valid, "R8", "zero length start quiet",
        {busy, req_valid}, 0);

    run(16'hFFF8, 16'd4, 40, 0, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule